// File: doc/BRIEF.md
# Wormhole Packet Router

This block is a small switch for an on-chip packet network. A few input ports each carry 32-bit flits, and the switch forwards them to one of several output ports. A packet is a run of flits. The first flit is the head and carries an 8-bit destination in its top byte. Zero or more body flits follow. The last flit is marked by an end-of-packet flag and carries a checksum of everything before it in the packet. The destination byte selects the output port through a fixed bit field, so the route never depends on traffic.

Switching is wormhole style. When a head reaches a free output, the switch grants that output to the requesting input and keeps the path reserved until the end-of-packet flit has gone through. Body flits flow as soon as they arrive. Heads from other inputs that want the same output wait with ready held low. If several heads want one free output in the same cycle, a round-robin pointer for that output picks the winner. Every output has a short FIFO, so a stalled consumer blocks only the one input that is locked to it. When the tail leaves the switch, the checksum result appears as a pulse beside it, and the packet is delivered either way.

Top module: `wormhole_router`

## Requirements
- R1: After reset, every `in_ready`, every `out_valid` and every `out_crc_err` bit is low.
- R2: A packet goes to the output numbered by bits [7:6] of the destination byte. The destination byte is bits [31:24] of the head flit. The same destination always selects the same output, and no other output receives any flit of that packet.
- R3: Consider a head that arrives at a free output. `in_ready` is low in the cycle the head is first presented and high in the next cycle. The flit shows on `out_valid`/`out_data` in the cycle after it is accepted.
- R4: Flits come out in arrival order with their data unchanged. Body flits are forwarded before the tail is offered.
- R5: While an output is held by one input, another input whose head targets that output sees `in_ready` low. Its packet starts only after the holder's tail has been accepted, and packets never interleave on an output.
- R6: When two inputs keep competing for one output, packets are granted to them alternately (round robin). One input never wins twice in a row while the other is waiting.
- R7: The tail flit is good when it equals the sum modulo 2^32 of the head and body flits of its packet. A bad tail raises `out_crc_err` only in the cycle that tail is transferred on the output (`out_valid` and `out_ready` high). The packet is still delivered whole.
- R8: Each output FIFO holds 4 flits. With `out_ready` low, the locked input gets exactly 4 flits accepted and then sees `in_ready` low. No flit is lost once the output drains.
- R9: Inputs routed to different outputs proceed at the same time. Both can have `in_ready` high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_IN | Per-input flit valid |
| in_data | input | NUM_IN*32 | Per-input flit data, input i at bits [32*i+31:32*i] |
| in_last | input | NUM_IN | Per-input end-of-packet marker (tail flit) |
| in_ready | output | NUM_IN | Per-input flit accepted when high together with valid |
| out_valid | output | NUM_OUT | Per-output flit valid |
| out_data | output | NUM_OUT*32 | Per-output flit data, output p at bits [32*p+31:32*p] |
| out_last | output | NUM_OUT | Per-output end-of-packet marker |
| out_crc_err | output | NUM_OUT | Pulse with a transferred tail whose checksum is wrong |
| out_ready | input | NUM_OUT | Per-output consumer ready |

## Verification
A wrong owner register or a stuck lock shows up within one or two cycles. A packet appears on an output other than the one its top destination bits name, or a waiting input stays stalled after the holder's tail. Flits from two sources may also mix on one output. A corrupted checksum accumulator stays hidden until the tail of the packet it affects. At that point `out_crc_err` fires with a good tail or stays quiet with a bad one. A miscounted FIFO occupancy shows at the input side as an accepted-flit count other than four while the consumer is stalled, or later as a missing or duplicated flit on the output.

// File: rtl/wr_pkg.sv
package wr_pkg;
   localparam int FLIT_W = 32;
   localparam int DEST_W = 8;

   typedef logic [FLIT_W-1:0] flit_t;

   // One stored output entry: payload, end marker, checksum verdict
   typedef struct packed {
      logic  bad;
      logic  last;
      flit_t data;
   } slot_t;
endpackage

// File: rtl/wr_in_ctl.sv
module wr_in_ctl
   import wr_pkg::*;
#(
   parameter int NUM_OUT = 4,
   parameter int SEL_LSB = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  flit_t              in_data,
   input  logic               in_last,
   input  logic               held,
   input  logic               route_full,
   output logic [NUM_OUT-1:0] req,
   output logic               in_ready,
   output logic               fire,
   output logic               tail_bad
);
   localparam int SEL_W   = $clog2(NUM_OUT);
   localparam int SEL_POS = FLIT_W - DEST_W + SEL_LSB;

   logic [SEL_W-1:0] sel;
   flit_t            acc;

   // Port field taken from the destination byte of the head flit
   assign sel = in_data[SEL_POS +: SEL_W];

   always_comb begin
      req = '0;
      if (in_valid && !held) req[sel] = 1'b1;
   end

   assign in_ready = held & ~route_full;
   assign fire     = in_valid & in_ready;
   assign tail_bad = in_last & (acc != in_data);

   // Running sum of the head and body flits of the packet in flight
   always_ff @(posedge clk) begin
      if (!rst_n)     acc <= '0;
      else if (fire)  acc <= in_last ? '0 : acc + in_data;
   end

   // R7
   acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && in_last) |=> (acc == '0));
endmodule

// File: rtl/wr_out_alloc.sv
module wr_out_alloc #(
   parameter int NUM_IN = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_IN-1:0]         req,
   input  logic                      tail_done,
   output logic                      locked,
   output logic [$clog2(NUM_IN)-1:0] owner
);
   localparam int IDX_W = $clog2(NUM_IN);

   logic [IDX_W-1:0] rr_ptr, winner, after_win;
   logic             found;
   int               cand;

   // Scan starts at the round-robin pointer and wraps past the last input
   always_comb begin
      found  = 1'b0;
      winner = '0;
      cand   = 0;
      for (int k = 0; k < NUM_IN; k++) begin
         cand = int'(rr_ptr) + k;
         if (cand >= NUM_IN) cand = cand - NUM_IN;
         if (!found && req[cand[IDX_W-1:0]]) begin
            found  = 1'b1;
            winner = cand[IDX_W-1:0];
         end
      end
   end

   assign after_win = (winner == IDX_W'(NUM_IN - 1)) ? '0 : winner + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked <= 1'b0;
         owner  <= '0;
         rr_ptr <= '0;
      end else if (!locked) begin
         if (found) begin
            locked <= 1'b1;
            owner  <= winner;
            rr_ptr <= after_win;
         end
      end else if (tail_done) begin
         locked <= 1'b0;
      end
   end

   // R5
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !tail_done) |=> (locked && $stable(owner)));
   // R6
   grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && (|req)) |=> (locked && (|($past(req) & (NUM_IN'(1) << owner)))));
   // R5
   idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && (req == '0)) |=> !locked);
endmodule

// File: rtl/wr_out_fifo.sv
module wr_out_fifo
   import wr_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  slot_t wr_slot,
   output logic  full,
   input  logic  rd_ready,
   output logic  rd_valid,
   output slot_t rd_slot
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   slot_t            mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nx, rd_nx;
   logic [CNT_W-1:0] cnt;
   logic             push, pop;

   assign full     = (cnt == CNT_W'(DEPTH));
   assign rd_valid = (cnt != '0);
   assign push     = wr_en & ~full;
   assign pop      = rd_valid & rd_ready;
   assign rd_slot  = mem[rd_ptr];

   // Power-of-two depth wraps for free; other depths compare against the end
   if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wr_nx = wr_ptr + 1'b1;
      assign rd_nx = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_nx;
         if (pop)  rd_ptr <= rd_nx;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wr_slot;
   end

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !full);
   // R8
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_ready) |=> full);
endmodule

// File: rtl/wormhole_router.sv
module wormhole_router
   import wr_pkg::*;
#(
   parameter int NUM_IN     = 3,
   parameter int NUM_OUT    = 4,
   parameter int FIFO_DEPTH = 4,
   parameter int SEL_LSB    = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_IN-1:0]         in_valid,
   input  logic [NUM_IN*FLIT_W-1:0]  in_data,
   input  logic [NUM_IN-1:0]         in_last,
   output logic [NUM_IN-1:0]         in_ready,
   output logic [NUM_OUT-1:0]        out_valid,
   output logic [NUM_OUT*FLIT_W-1:0] out_data,
   output logic [NUM_OUT-1:0]        out_last,
   output logic [NUM_OUT-1:0]        out_crc_err,
   input  logic [NUM_OUT-1:0]        out_ready
);
   localparam int SEL_W = $clog2(NUM_OUT);
   localparam int IDX_W = $clog2(NUM_IN);

   if (NUM_IN < 2) begin : g_bad_in
      $fatal(1, "NUM_IN must be at least 2");
   end
   if (NUM_OUT < 2 || NUM_OUT != (1 << SEL_W)) begin : g_bad_out
      $fatal(1, "NUM_OUT must be a power of two, at least 2");
   end
   if (SEL_LSB < 0 || SEL_LSB + SEL_W > DEST_W) begin : g_bad_sel
      $fatal(1, "port field must lie inside the destination byte");
   end
   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $fatal(1, "FIFO_DEPTH must be at least 2");
   end

   flit_t              in_flit   [NUM_IN];
   logic [NUM_OUT-1:0] req_m     [NUM_IN];
   logic [NUM_OUT-1:0] own_m     [NUM_IN];
   logic [SEL_W-1:0]   hold_port [NUM_IN];
   logic [NUM_IN-1:0]  held, route_full, fire, tail_bad;

   logic [NUM_IN-1:0]  req_t     [NUM_OUT];
   logic [IDX_W-1:0]   owner     [NUM_OUT];
   slot_t              wr_slot   [NUM_OUT];
   slot_t              rd_slot   [NUM_OUT];
   logic [NUM_OUT-1:0] locked, full, wr_en, tail_done;

   // Which output, if any, each input currently holds
   always_comb begin
      for (int i = 0; i < NUM_IN; i++) begin
         own_m[i]     = '0;
         hold_port[i] = '0;
         for (int p = 0; p < NUM_OUT; p++) begin
            if (locked[p] && owner[p] == IDX_W'(i)) begin
               own_m[i][p]  = 1'b1;
               hold_port[i] = SEL_W'(p);
            end
         end
         held[i]       = |own_m[i];
         route_full[i] = full[hold_port[i]];
      end
   end

   // Crossbar: each output takes the flit of its owner
   always_comb begin
      for (int p = 0; p < NUM_OUT; p++) begin
         for (int i = 0; i < NUM_IN; i++) req_t[p][i] = req_m[i][p];
         wr_en[p]        = locked[p] & fire[owner[p]];
         wr_slot[p].bad  = tail_bad[owner[p]];
         wr_slot[p].last = in_last[owner[p]];
         wr_slot[p].data = in_flit[owner[p]];
         tail_done[p]    = wr_en[p] & in_last[owner[p]];
      end
   end

   for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
      assign in_flit[gi] = in_data[gi*FLIT_W +: FLIT_W];

      wr_in_ctl #(
         .NUM_OUT (NUM_OUT),
         .SEL_LSB (SEL_LSB)
      ) u_in (
         .clk        (clk),
         .rst_n      (rst_n),
         .in_valid   (in_valid[gi]),
         .in_data    (in_flit[gi]),
         .in_last    (in_last[gi]),
         .held       (held[gi]),
         .route_full (route_full[gi]),
         .req        (req_m[gi]),
         .in_ready   (in_ready[gi]),
         .fire       (fire[gi]),
         .tail_bad   (tail_bad[gi])
      );

      // R5
      one_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(own_m[gi]));
   end

   for (genvar go = 0; go < NUM_OUT; go++) begin : g_out
      wr_out_alloc #(
         .NUM_IN (NUM_IN)
      ) u_alloc (
         .clk       (clk),
         .rst_n     (rst_n),
         .req       (req_t[go]),
         .tail_done (tail_done[go]),
         .locked    (locked[go]),
         .owner     (owner[go])
      );

      wr_out_fifo #(
         .DEPTH (FIFO_DEPTH)
      ) u_fifo (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_en[go]),
         .wr_slot  (wr_slot[go]),
         .full     (full[go]),
         .rd_ready (out_ready[go]),
         .rd_valid (out_valid[go]),
         .rd_slot  (rd_slot[go])
      );

      assign out_data[go*FLIT_W +: FLIT_W] = rd_slot[go].data;
      assign out_last[go]    = rd_slot[go].last;
      assign out_crc_err[go] = out_valid[go] & out_ready[go]
                             & rd_slot[go].last & rd_slot[go].bad;
   end
endmodule

// File: tb/test_wormhole_router.sv
`timescale 1ns/1ps
module test_wormhole_router;
   localparam int NI = 3;
   localparam int NO = 4;
   localparam int MD = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        tv [NI];
   logic [31:0] td [NI];
   logic        tl [NI];
   logic        ordy [NO];

   logic [NI-1:0]    in_valid, in_last, in_ready;
   logic [NI*32-1:0] in_data;
   logic [NO-1:0]    out_valid, out_last, out_crc_err, out_ready;
   logic [NO*32-1:0] out_data;

   always_comb begin
      for (int i = 0; i < NI; i++) begin
         in_valid[i]         = tv[i];
         in_last[i]          = tl[i];
         in_data[i*32 +: 32] = td[i];
      end
      for (int p = 0; p < NO; p++) out_ready[p] = ordy[p];
   end

   wormhole_router i_wormhole_router (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_data     (in_data),
      .in_last     (in_last),
      .in_ready    (in_ready),
      .out_valid   (out_valid),
      .out_data    (out_data),
      .out_last    (out_last),
      .out_crc_err (out_crc_err),
      .out_ready   (out_ready)
   );

   // Port monitors: record transfers on both sides
   logic [31:0] m_data [NO][MD];
   logic        m_last [NO][MD];
   logic        m_err  [NO][MD];
   int          m_cnt  [NO];
   int          acc_cnt [NI];
   int          stray_err = 0;
   int          both_cnt = 0;

   initial begin
      for (int p = 0; p < NO; p++) m_cnt[p] = 0;
      for (int i = 0; i < NI; i++) acc_cnt[i] = 0;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         for (int p = 0; p < NO; p++) begin
            if (out_crc_err[p] && !(out_valid[p] && out_ready[p] && out_last[p]))
               stray_err = stray_err + 1;
            if (out_valid[p] && out_ready[p] && m_cnt[p] < MD) begin
               m_data[p][m_cnt[p]] = out_data[p*32 +: 32];
               m_last[p][m_cnt[p]] = out_last[p];
               m_err[p][m_cnt[p]]  = out_crc_err[p];
               m_cnt[p] = m_cnt[p] + 1;
            end
         end
         for (int i = 0; i < NI; i++)
            if (tv[i] && in_ready[i]) acc_cnt[i] = acc_cnt[i] + 1;
         if (in_ready[0] && in_ready[1]) both_cnt = both_cnt + 1;
      end
   end

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      report();
   end

   // Flit k of a packet: 0 is head, 1..nbody body, nbody+1 the checksum tail
   function automatic logic [31:0] exp_flit(input int src, input logic [7:0] dest,
         input logic [15:0] id, input int nbody, input bit corrupt, input int k);
      logic [31:0] head, sum, b;
      head = {dest, 8'(src), id};
      if (k == 0) return head;
      sum = head;
      for (int j = 1; j <= nbody; j++) begin
         b = head ^ 32'(32'h9E37_79B9 * 32'(j));
         if (j == k) return b;
         sum = sum + b;
      end
      return corrupt ? (sum ^ 32'h0000_0100) : sum;
   endfunction

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send_flit(input int i, input logic [31:0] d, input logic l);
      tv[i] = 1'b1;
      td[i] = d;
      tl[i] = l;
      do @(negedge clk); while (!in_ready[i]);
      @(posedge clk);
      #1;
      tv[i] = 1'b0;
      tl[i] = 1'b0;
   endtask

   task automatic send_pkt(input int i, input logic [7:0] dest, input logic [15:0] id,
                           input int nbody, input bit corrupt);
      for (int k = 0; k <= nbody + 1; k++)
         send_flit(i, exp_flit(i, dest, id, nbody, corrupt, k), k == nbody + 1);
   endtask

   task automatic expect_pkt(input int p, input int base, input int src,
         input logic [7:0] dest, input logic [15:0] id, input int nbody,
         input bit corrupt, input string rq);
      for (int k = 0; k <= nbody + 1; k++) begin
         chk(m_data[p][base+k] === exp_flit(src, dest, id, nbody, corrupt, k),
             rq, m_data[p][base+k], exp_flit(src, dest, id, nbody, corrupt, k));
         chk(m_last[p][base+k] === (k == nbody + 1), rq,
             32'(m_last[p][base+k]), 32'(k == nbody + 1));
         chk(m_err[p][base+k] === (corrupt && k == nbody + 1), rq,
             32'(m_err[p][base+k]), 32'(corrupt && k == nbody + 1));
      end
   endtask

   initial begin
      int base, b2, occ0, occ2, src_a, src_b;
      int snap [NO];
      bit ok;
      for (int i = 0; i < NI; i++) begin
         tv[i] = 1'b0; td[i] = '0; tl[i] = 1'b0;
      end
      for (int p = 0; p < NO; p++) ordy[p] = 1'b1;

      idle(4);
      @(negedge clk);
      // R1: idle state after reset
      chk(in_ready == '0, "R1", 32'(in_ready), 0);
      chk(out_valid == '0, "R1", 32'(out_valid), 0);
      chk(out_crc_err == '0, "R1", 32'(out_crc_err), 0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      idle(2);

      // R3: one allocation cycle, then one cycle through the output FIFO
      base = m_cnt[1];
      ordy[1] = 1'b0;
      tv[0] = 1'b1; td[0] = exp_flit(0, 8'h40, 16'h0300, 1, 0, 0); tl[0] = 1'b0;
      @(negedge clk);
      chk(in_ready[0] == 1'b0, "R3 ready in request cycle", 32'(in_ready[0]), 0);
      @(negedge clk);
      chk(in_ready[0] == 1'b1, "R3 ready after grant", 32'(in_ready[0]), 1);
      @(posedge clk);
      #1;
      tv[0] = 1'b0;
      @(negedge clk);
      chk(out_valid[1] == 1'b1, "R3 output valid", 32'(out_valid[1]), 1);
      chk(out_data[32 +: 32] == exp_flit(0, 8'h40, 16'h0300, 1, 0, 0), "R3 output data",
          out_data[32 +: 32], exp_flit(0, 8'h40, 16'h0300, 1, 0, 0));
      @(posedge clk);
      #1;
      ordy[1] = 1'b1;
      send_flit(0, exp_flit(0, 8'h40, 16'h0300, 1, 0, 1), 1'b0);
      send_flit(0, exp_flit(0, 8'h40, 16'h0300, 1, 0, 2), 1'b1);
      idle(4);
      expect_pkt(1, base, 0, 8'h40, 16'h0300, 1, 0, "R3 packet");

      // R4: body flits leave before the tail is offered
      base = m_cnt[2];
      send_flit(1, exp_flit(1, 8'h85, 16'h0400, 3, 0, 0), 1'b0);
      send_flit(1, exp_flit(1, 8'h85, 16'h0400, 3, 0, 1), 1'b0);
      send_flit(1, exp_flit(1, 8'h85, 16'h0400, 3, 0, 2), 1'b0);
      idle(4);
      chk(m_cnt[2] - base == 3, "R4 forwarded before tail", 32'(m_cnt[2] - base), 3);
      send_flit(1, exp_flit(1, 8'h85, 16'h0400, 3, 0, 3), 1'b0);
      send_flit(1, exp_flit(1, 8'h85, 16'h0400, 3, 0, 4), 1'b1);
      idle(4);
      expect_pkt(2, base, 1, 8'h85, 16'h0400, 3, 0, "R4 order and data");

      // R5: a held output blocks a second input until the tail passes
      base = m_cnt[3];
      send_flit(0, exp_flit(0, 8'hC1, 16'h0500, 1, 0, 0), 1'b0);
      send_flit(0, exp_flit(0, 8'hC1, 16'h0500, 1, 0, 1), 1'b0);
      tv[2] = 1'b1; td[2] = exp_flit(2, 8'hF0, 16'h0501, 2, 0, 0); tl[2] = 1'b0;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         chk(in_ready[2] == 1'b0, "R5 blocked while held", 32'(in_ready[2]), 0);
      end
      @(posedge clk);
      #1;
      fork
         send_flit(0, exp_flit(0, 8'hC1, 16'h0500, 1, 0, 2), 1'b1);
         send_pkt(2, 8'hF0, 16'h0501, 2, 0);
      join
      idle(6);
      expect_pkt(3, base, 0, 8'hC1, 16'h0500, 1, 0, "R5 holder packet");
      expect_pkt(3, base + 3, 2, 8'hF0, 16'h0501, 2, 0, "R5 waiter packet");

      // R6: two inputs competing for output 0 alternate
      base = m_cnt[0];
      fork
         begin
            send_pkt(0, 8'h10, 16'h0600, 1, 0);
            send_pkt(0, 8'h11, 16'h0601, 1, 0);
         end
         begin
            send_pkt(2, 8'h20, 16'h0610, 1, 0);
            send_pkt(2, 8'h21, 16'h0611, 1, 0);
         end
      join
      idle(6);
      chk(m_cnt[0] - base == 12, "R6 flit count", 32'(m_cnt[0] - base), 12);
      occ0 = 0;
      occ2 = 0;
      for (int j = 0; j < 4; j++) begin
         src_a = int'(m_data[0][base + 3*j][23:16]);
         if (j < 3) begin
            src_b = int'(m_data[0][base + 3*j + 3][23:16]);
            chk(src_a != src_b, "R6 alternation", 32'(src_b), 32'(src_a == 0 ? 2 : 0));
         end
         if (src_a == 0) begin
            expect_pkt(0, base + 3*j, 0, 8'(8'h10 + occ0), 16'(16'h0600 + occ0), 1, 0, "R6 packet");
            occ0++;
         end else begin
            expect_pkt(0, base + 3*j, 2, 8'(8'h20 + occ2), 16'(16'h0610 + occ2), 1, 0, "R6 packet");
            occ2++;
         end
      end

      // R7: bad checksum pulses with the tail, packet still delivered
      base = m_cnt[0];
      send_pkt(1, 8'h2A, 16'h0700, 2, 1);
      send_pkt(1, 8'h2B, 16'h0701, 2, 0);
      idle(6);
      expect_pkt(0, base, 1, 8'h2A, 16'h0700, 2, 1, "R7 bad tail");
      expect_pkt(0, base + 4, 1, 8'h2B, 16'h0701, 2, 0, "R7 good tail");

      // R8: four-entry output FIFO backpressures the locked input
      base = m_cnt[2];
      b2 = acc_cnt[2];
      ordy[2] = 1'b0;
      fork
         send_pkt(2, 8'h80, 16'h0800, 6, 0);
      join_none
      idle(12);
      @(negedge clk);
      chk(in_ready[2] == 1'b0, "R8 full stalls input", 32'(in_ready[2]), 0);
      chk(acc_cnt[2] - b2 == 4, "R8 accepted count", 32'(acc_cnt[2] - b2), 4);
      @(posedge clk);
      #1;
      ordy[2] = 1'b1;
      wait fork;
      idle(8);
      expect_pkt(2, base, 2, 8'h80, 16'h0800, 6, 0, "R8 no loss");

      // R9: disjoint routes run concurrently
      base = m_cnt[0];
      b2 = m_cnt[3];
      src_a = both_cnt;
      fork
         send_pkt(0, 8'h05, 16'h0900, 6, 0);
         send_pkt(1, 8'hC5, 16'h0901, 6, 0);
      join
      idle(6);
      chk(both_cnt > src_a, "R9 simultaneous ready", 32'(both_cnt - src_a), 1);
      expect_pkt(0, base, 0, 8'h05, 16'h0900, 6, 0, "R9 output 0");
      expect_pkt(3, b2, 1, 8'hC5, 16'h0901, 6, 0, "R9 output 3");

      // R2: every destination byte routed by its top two bits
      for (int d = 0; d < 256; d++) begin
         for (int p = 0; p < NO; p++) snap[p] = m_cnt[p];
         send_pkt(d % NI, 8'(d), 16'(d), 1, 0);
         idle(4);
         ok = 1'b1;
         for (int p = 0; p < NO; p++)
            if (m_cnt[p] - snap[p] != ((p == d / 64) ? 3 : 0)) ok = 1'b0;
         chk(ok, "R2 route select", 32'(m_cnt[d/64] - snap[d/64]), 3);
         expect_pkt(d / 64, snap[d/64], d % NI, 8'(d), 16'(d), 1, 0, "R2 data");
      end

      chk(stray_err == 0, "R7 no pulse off tail", 32'(stray_err), 0);
      report();
   end
endmodule